// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by reading descriptors from a two-level translation table in memory. A requester offers a virtual address together with the table base over a valid/ready handshake. The walker then reads one first-level descriptor and, when that descriptor points at a second-level table, one more descriptor. It has a word-read port whose grant and data return may each take any number of cycles. Only one walk is in flight at a time.

The result gives the physical address, the cacheable and bufferable attributes, the 4-bit domain, the 2-bit access-permission code for the addressed 1 KB subpage, and a fault flag. Three mapping sizes are resolved: 1 MB sections from the first level, and 64 KB large pages and 4 KB small pages from the second level. The permission code is passed through and never enforced. Its meaning is: 0 is supervisor read-only, 1 is supervisor read-write, 2 is supervisor read-write with user read-only, and 3 is full access for both. Domain checks and any translation caching are left to surrounding logic.

Top module: `tt_walker`

## Requirements
- R1: `req_ready` is 1 only while no walk is in progress. After a request is accepted (`req_valid` and `req_ready` both 1 at a clock edge), `req_ready` is 0 until the response cycle is over. While `req_ready` is 1, `mem_rd` and `rsp_valid` are 0.
- R2: The first read goes to `{req_base[31:14], va[31:20], 2'b00}`. The low 14 bits of the base have no effect on any result.
- R3: A first-level descriptor with bits [1:0] = 10 is a section, and the walk ends after that single read. The result is: `rsp_pa = {desc[31:20], va[19:0]}`, `rsp_ap = desc[11:10]`, `rsp_domain = desc[8:5]`, `rsp_cache = desc[3]`, `rsp_bufable = desc[2]`.
- R4: A first-level descriptor with bits [1:0] = 00 or 11 gives a fault after exactly one read.
- R5: A first-level descriptor with bits [1:0] = 01 causes a second read at `{desc[31:10], va[19:12], 2'b00}`.
- R6: A second-level descriptor with bits [1:0] = 01 is a large page. The result is `rsp_pa = {desc[31:16], va[15:0]}`, and `rsp_ap` is the field at bits [2k+5:2k+4] of the descriptor, where k = va[15:14].
- R7: A second-level descriptor with bits [1:0] = 10 is a small page. The result is `rsp_pa = {desc[31:12], va[11:0]}`, and `rsp_ap` is the field at bits [2k+5:2k+4] of the descriptor, where k = va[11:10].
- R8: A second-level descriptor with bits [1:0] = 00 or 11 gives a fault after exactly two reads.
- R9: For both page sizes, `rsp_cache` is bit 3 and `rsp_bufable` is bit 2 of the second-level descriptor, and `rsp_domain` is bits [8:5] of the first-level descriptor.
- R10: On a fault, `rsp_fault` is 1 and `rsp_pa`, `rsp_ap`, `rsp_domain`, `rsp_cache` and `rsp_bufable` are all 0. On a successful translation, `rsp_fault` is 0.
- R11: While `mem_rd` is 1 and `mem_gnt` is 0, both `mem_rd` and `mem_addr` hold their values into the next cycle. After the edge at which the grant is taken, `mem_rd` is 0.
- R12: `rsp_valid` is 1 for exactly one cycle per accepted request. That cycle is the one right after the edge that samples `mem_rvalid` with the final descriptor.
- R13: During and right after reset, `req_ready` is 1 and `mem_rd` and `rsp_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request offered |
| req_ready | output | 1 | Walker idle, request will be taken |
| req_va | input | 32 | Virtual address to translate |
| req_base | input | 32 | First-level table base (low 14 bits unused) |
| mem_rd | output | 1 | Word read requested |
| mem_addr | output | 32 | Byte address of the descriptor to read |
| mem_gnt | input | 1 | Read request accepted this cycle |
| mem_rvalid | input | 1 | Read data valid this cycle |
| mem_rdata | input | 32 | Descriptor word |
| rsp_valid | output | 1 | Result valid, one cycle |
| rsp_pa | output | 32 | Physical address (0 on fault) |
| rsp_cache | output | 1 | Cacheable attribute |
| rsp_bufable | output | 1 | Bufferable attribute |
| rsp_domain | output | 4 | Domain number |
| rsp_ap | output | 2 | Selected permission code |
| rsp_fault | output | 1 | Translation fault |

## Verification
No result has a fixed latency from the request, because the grant delay and the data latency vary. The bench therefore times each result from the memory side: the read address is compared in the first cycle `mem_rd` is seen. It is then compared again in every cycle the grant is held back. The response must appear in the cycle after the edge that samples the last `mem_rvalid`. The bench records that cycle when it drives the data and compares it with the cycle in which `rsp_valid` is seen. The number of reads per walk is also counted, which separates one-read outcomes (sections, first-level faults) from two-read outcomes.

// File: rtl/tw_pkg.sv
package tw_pkg;
  parameter int unsigned AW          = 32;
  parameter int unsigned L1_IDX_W    = 12;
  parameter int unsigned L2_IDX_W    = 8;
  parameter int unsigned SECT_W      = 20;
  parameter int unsigned PG_LARGE_W  = 16;
  parameter int unsigned PG_SMALL_W  = 12;
  parameter int unsigned TBL_ALIGN_W = 14;
  parameter int unsigned L2_ALIGN_W  = 10;
  parameter int unsigned AP_W        = 2;
  parameter int unsigned SUBPAGES    = 4;
  parameter int unsigned DOM_W       = 4;

  localparam int unsigned SEL_W       = $clog2(SUBPAGES);
  localparam int unsigned AP_LSB      = 4;
  localparam int unsigned SECT_AP_LSB = 10;
  localparam int unsigned DOM_LSB     = 5;
  localparam int unsigned BUF_BIT     = 2;
  localparam int unsigned CACHE_BIT   = 3;

  typedef enum logic [1:0] {
    L1K_FAULT,
    L1K_TABLE,
    L1K_SECTION
  } l1_kind_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_L1_REQ,
    ST_L1_WAIT,
    ST_L2_REQ,
    ST_L2_WAIT,
    ST_DONE
  } tw_state_e;

  typedef struct packed {
    logic [AW-1:0]    pa;
    logic             cache;
    logic             bufable;
    logic [DOM_W-1:0] dom;
    logic [AP_W-1:0]  ap;
    logic             fault;
  } tw_result_t;
endpackage

// File: rtl/tw_l1_dec.sv
module tw_l1_dec
  import tw_pkg::*;
(
  input  logic [AW-1:0]    desc,
  input  logic [AW-1:0]    va,
  output l1_kind_e         kind,
  output tw_result_t       sect_res,
  output logic [AW-1:0]    l2_addr,
  output logic [DOM_W-1:0] dom
);

  always_comb begin
    unique case (desc[1:0])
      2'b01:   kind = L1K_TABLE;
      2'b10:   kind = L1K_SECTION;
      default: kind = L1K_FAULT;
    endcase
  end

  assign dom = desc[DOM_LSB +: DOM_W];

  always_comb begin
    sect_res         = '0;
    sect_res.pa      = {desc[AW-1:SECT_W], va[SECT_W-1:0]};
    sect_res.cache   = desc[CACHE_BIT];
    sect_res.bufable = desc[BUF_BIT];
    sect_res.dom     = desc[DOM_LSB +: DOM_W];
    sect_res.ap      = desc[SECT_AP_LSB +: AP_W];
    sect_res.fault   = 1'b0;
  end

  assign l2_addr = {desc[AW-1:L2_ALIGN_W], va[SECT_W-1 -: L2_IDX_W], 2'b00};

endmodule

// File: rtl/tw_l2_dec.sv
module tw_l2_dec
  import tw_pkg::*;
(
  input  logic [AW-1:0]    desc,
  input  logic [AW-1:0]    va,
  input  logic [DOM_W-1:0] dom,
  output tw_result_t       res
);

  logic [AP_W-1:0]  ap_field [SUBPAGES];
  logic [SEL_W-1:0] sel_large;
  logic [SEL_W-1:0] sel_small;

  for (genvar i = 0; i < SUBPAGES; i++) begin : g_apf
    assign ap_field[i] = desc[AP_LSB + i*AP_W +: AP_W];
  end

  assign sel_large = va[PG_LARGE_W-1 -: SEL_W];
  assign sel_small = va[PG_SMALL_W-1 -: SEL_W];

  always_comb begin
    res = '0;
    unique case (desc[1:0])
      2'b01: begin
        res.pa      = {desc[AW-1:PG_LARGE_W], va[PG_LARGE_W-1:0]};
        res.ap      = ap_field[sel_large];
        res.cache   = desc[CACHE_BIT];
        res.bufable = desc[BUF_BIT];
        res.dom     = dom;
      end
      2'b10: begin
        res.pa      = {desc[AW-1:PG_SMALL_W], va[PG_SMALL_W-1:0]};
        res.ap      = ap_field[sel_small];
        res.cache   = desc[CACHE_BIT];
        res.bufable = desc[BUF_BIT];
        res.dom     = dom;
      end
      default: begin
        res.fault = 1'b1;
      end
    endcase
  end

endmodule

// File: rtl/tw_seq.sv
module tw_seq
  import tw_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [AW-1:0]    req_va,
  input  logic [AW-1:0]    req_base,
  output logic             mem_rd,
  output logic [AW-1:0]    mem_addr,
  input  logic             mem_gnt,
  input  logic             mem_rvalid,
  input  l1_kind_e         l1_kind,
  input  tw_result_t       l1_res,
  input  logic [AW-1:0]    l1_l2_addr,
  input  logic [DOM_W-1:0] l1_dom,
  input  tw_result_t       l2_res,
  output logic [AW-1:0]    va_q,
  output logic [DOM_W-1:0] dom_q,
  output logic             rsp_valid,
  output tw_result_t       rsp
);

  tw_state_e        state_q, state_d;
  logic [AW-1:TBL_ALIGN_W] base_q;
  logic [AW-1:0]    l2_addr_q;
  tw_result_t       res_q, res_d;
  tw_result_t       flt;
  logic             ld_req, ld_l1, ld_res;
  logic [AW-1:0]    l1_addr;

  always_comb begin
    flt       = '0;
    flt.fault = 1'b1;
  end

  always_comb begin
    state_d = state_q;
    ld_req  = 1'b0;
    ld_l1   = 1'b0;
    ld_res  = 1'b0;
    res_d   = flt;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          ld_req  = 1'b1;
          state_d = ST_L1_REQ;
        end
      end
      ST_L1_REQ: begin
        if (mem_gnt) state_d = ST_L1_WAIT;
      end
      ST_L1_WAIT: begin
        if (mem_rvalid) begin
          unique case (l1_kind)
            L1K_SECTION: begin
              ld_res  = 1'b1;
              res_d   = l1_res;
              state_d = ST_DONE;
            end
            L1K_TABLE: begin
              ld_l1   = 1'b1;
              state_d = ST_L2_REQ;
            end
            default: begin
              ld_res  = 1'b1;
              res_d   = flt;
              state_d = ST_DONE;
            end
          endcase
        end
      end
      ST_L2_REQ: begin
        if (mem_gnt) state_d = ST_L2_WAIT;
      end
      ST_L2_WAIT: begin
        if (mem_rvalid) begin
          ld_res  = 1'b1;
          res_d   = l2_res;
          state_d = ST_DONE;
        end
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      va_q   <= '0;
      base_q <= '0;
    end else if (ld_req) begin
      va_q   <= req_va;
      base_q <= req_base[AW-1:TBL_ALIGN_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      l2_addr_q <= '0;
      dom_q     <= '0;
    end else if (ld_l1) begin
      l2_addr_q <= l1_l2_addr;
      dom_q     <= l1_dom;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      res_q <= '0;
    else if (ld_res) res_q <= res_d;
  end

  assign l1_addr   = {base_q, va_q[AW-1 -: L1_IDX_W], 2'b00};
  assign req_ready = (state_q == ST_IDLE);
  assign mem_rd    = (state_q == ST_L1_REQ) || (state_q == ST_L2_REQ);
  assign mem_addr  = (state_q == ST_L2_REQ) ? l2_addr_q : l1_addr;
  assign rsp_valid = (state_q == ST_DONE);
  assign rsp       = res_q;

endmodule

// File: rtl/tt_walker.sv
module tt_walker
  import tw_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [AW-1:0]    req_va,
  input  logic [AW-1:0]    req_base,
  output logic             mem_rd,
  output logic [AW-1:0]    mem_addr,
  input  logic             mem_gnt,
  input  logic             mem_rvalid,
  input  logic [AW-1:0]    mem_rdata,
  output logic             rsp_valid,
  output logic [AW-1:0]    rsp_pa,
  output logic             rsp_cache,
  output logic             rsp_bufable,
  output logic [DOM_W-1:0] rsp_domain,
  output logic [AP_W-1:0]  rsp_ap,
  output logic             rsp_fault
);

  l1_kind_e         l1_kind;
  tw_result_t       l1_res;
  tw_result_t       l2_res;
  tw_result_t       rsp;
  logic [AW-1:0]    l1_l2_addr;
  logic [DOM_W-1:0] l1_dom;
  logic [AW-1:0]    va_q;
  logic [DOM_W-1:0] dom_q;

  tw_l1_dec u_l1 (
    .desc     (mem_rdata),
    .va       (va_q),
    .kind     (l1_kind),
    .sect_res (l1_res),
    .l2_addr  (l1_l2_addr),
    .dom      (l1_dom)
  );

  tw_l2_dec u_l2 (
    .desc (mem_rdata),
    .va   (va_q),
    .dom  (dom_q),
    .res  (l2_res)
  );

  tw_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_va     (req_va),
    .req_base   (req_base),
    .mem_rd     (mem_rd),
    .mem_addr   (mem_addr),
    .mem_gnt    (mem_gnt),
    .mem_rvalid (mem_rvalid),
    .l1_kind    (l1_kind),
    .l1_res     (l1_res),
    .l1_l2_addr (l1_l2_addr),
    .l1_dom     (l1_dom),
    .l2_res     (l2_res),
    .va_q       (va_q),
    .dom_q      (dom_q),
    .rsp_valid  (rsp_valid),
    .rsp        (rsp)
  );

  assign rsp_pa      = rsp.pa;
  assign rsp_cache   = rsp.cache;
  assign rsp_bufable = rsp.bufable;
  assign rsp_domain  = rsp.dom;
  assign rsp_ap      = rsp.ap;
  assign rsp_fault   = rsp.fault;

endmodule

// File: rtl/tw_checker.sv
module tw_checker
  import tw_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic             mem_rd,
  input logic [AW-1:0]    mem_addr,
  input logic             mem_gnt,
  input logic             mem_rvalid,
  input logic             rsp_valid,
  input logic [AW-1:0]    rsp_pa,
  input logic             rsp_cache,
  input logic             rsp_bufable,
  input logic [DOM_W-1:0] rsp_domain,
  input logic [AP_W-1:0]  rsp_ap,
  input logic             rsp_fault
);

  assert_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready);

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mem_rd && !rsp_valid);

  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd && !mem_gnt |=> mem_rd && $stable(mem_addr));

  assert_drop_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd && mem_gnt |=> !mem_rd);

  assert_one_shot_R12: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  assert_after_data_R12: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(mem_rvalid));

  assert_fault_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fault |-> rsp_pa == '0 && rsp_ap == '0 && rsp_domain == '0
                               && !rsp_cache && !rsp_bufable);

endmodule

bind tt_walker tw_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .mem_rd      (mem_rd),
  .mem_addr    (mem_addr),
  .mem_gnt     (mem_gnt),
  .mem_rvalid  (mem_rvalid),
  .rsp_valid   (rsp_valid),
  .rsp_pa      (rsp_pa),
  .rsp_cache   (rsp_cache),
  .rsp_bufable (rsp_bufable),
  .rsp_domain  (rsp_domain),
  .rsp_ap      (rsp_ap),
  .rsp_fault   (rsp_fault)
);

// File: tb/sim_tt_walker.sv
`timescale 1ns/1ps
module sim_tt_walker;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_va = '0;
  logic [31:0] req_base = '0;
  logic        mem_rd;
  logic [31:0] mem_addr;
  logic        mem_gnt = 1'b0;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_pa;
  logic        rsp_cache, rsp_bufable, rsp_fault;
  logic [3:0]  rsp_domain;
  logic [1:0]  rsp_ap;

  always #2 clk = ~clk;

  tt_walker u0 (.*);

  typedef struct {
    logic [31:0] pa;
    logic        c;
    logic        b;
    logic [3:0]  dom;
    logic [1:0]  ap;
    logic        f;
    int          nrd;
    string       tag;
  } exp_t;

  logic [31:0] mem [logic [31:0]];
  exp_t        exp_q [$];
  logic [31:0] addr_q [$];
  int          n_chk = 0, n_fail = 0, cyc = 0, last_rv = 0, rd_cnt = 0, seq = 0;
  bit          done = 1'b0;

  initial forever begin
    @(posedge clk);
    cyc <= cyc + 1;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  function automatic logic [31:0] lk(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  task automatic put_l2(input logic [31:0] l2base, input logic [31:0] va, input logic [31:0] d);
    mem[{l2base[31:10], va[19:12], 2'b00}] = d;
  endtask

  // Expected result straight from the requirements (R2..R10).
  task automatic walk(input logic [31:0] va, input logic [31:0] base, input string tag);
    exp_t e;
    logic [31:0] a1, a2, d1, d2;
    int k;
    e = '{pa: 0, c: 0, b: 0, dom: 0, ap: 0, f: 1, nrd: 1, tag: tag};
    a1 = {base[31:14], va[31:20], 2'b00};
    d1 = lk(a1);
    addr_q.push_back(a1);
    if (d1[1:0] == 2'b10) begin
      e = '{pa: {d1[31:20], va[19:0]}, c: d1[3], b: d1[2], dom: d1[8:5],
            ap: d1[11:10], f: 0, nrd: 1, tag: tag};
    end else if (d1[1:0] == 2'b01) begin
      a2 = {d1[31:10], va[19:12], 2'b00};
      d2 = lk(a2);
      addr_q.push_back(a2);
      e.nrd = 2;
      if (d2[1:0] == 2'b01 || d2[1:0] == 2'b10) begin
        k = (d2[1:0] == 2'b01) ? int'(va[15:14]) : int'(va[11:10]);
        e.pa  = (d2[1:0] == 2'b01) ? {d2[31:16], va[15:0]} : {d2[31:12], va[11:0]};
        e.c   = d2[3];
        e.b   = d2[2];
        e.dom = d1[8:5];
        e.ap  = d2[4 + 2*k +: 2];
        e.f   = 1'b0;
      end
    end
    exp_q.push_back(e);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_va    = va;
    req_base  = base;
    req_valid = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b0, "R1 busy after accept", {31'b0, req_ready}, 32'h0);
    req_valid = 1'b0;
    req_va    = 32'hDEAD_BEEF;
    req_base  = 32'hFFFF_FFFF;
  endtask

  // Memory responder: variable grant delay and data latency.
  initial begin
    logic [31:0] a, ea;
    int gd, lat;
    forever begin
      @(negedge clk);
      if (mem_rd && rst_n) begin
        a  = mem_addr;
        ea = (addr_q.size() > 0) ? addr_q.pop_front() : 32'hFFFF_FFFF;
        chk(a == ea, "R2/R5 read address", a, ea);
        gd  = seq % 3;
        lat = (seq / 2) % 4;
        seq++;
        for (int i = 0; i < gd; i++) begin
          @(negedge clk);
          chk(mem_rd && mem_addr == a, "R11 hold before grant", mem_addr, a);
        end
        mem_gnt = 1'b1;
        @(negedge clk);
        mem_gnt = 1'b0;
        chk(!mem_rd, "R11 drop after grant", {31'b0, mem_rd}, 32'h0);
        for (int i = 0; i < lat; i++) @(negedge clk);
        mem_rvalid = 1'b1;
        mem_rdata  = lk(a);
        last_rv    = cyc;
        rd_cnt++;
        @(negedge clk);
        mem_rvalid = 1'b0;
        mem_rdata  = 32'h5A5A_5A5A;
      end
    end
  end

  // Scoreboard monitor.
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      if (rsp_valid) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R12 unexpected response", 32'h1, 32'h0);
        end else begin
          e = exp_q.pop_front();
          chk(rsp_pa == e.pa, {e.tag, " pa"}, rsp_pa, e.pa);
          chk(rsp_fault == e.f, {e.tag, " fault"}, {31'b0, rsp_fault}, {31'b0, e.f});
          chk(rsp_ap == e.ap, {e.tag, " ap"}, {30'b0, rsp_ap}, {30'b0, e.ap});
          chk(rsp_domain == e.dom, {e.tag, " domain R9"}, {28'b0, rsp_domain}, {28'b0, e.dom});
          chk({rsp_cache, rsp_bufable} == {e.c, e.b}, {e.tag, " attr R9"},
              {30'b0, rsp_cache, rsp_bufable}, {30'b0, e.c, e.b});
          chk(rd_cnt == e.nrd, {e.tag, " read count R4/R8"}, rd_cnt, e.nrd);
          chk(cyc == last_rv + 1, "R12 response cycle", cyc, last_rv + 1);
        end
        rd_cnt = 0;
        @(negedge clk);
        chk(!rsp_valid, "R12 single cycle", {31'b0, rsp_valid}, 32'h0);
      end
    end
  end

  task automatic summary;
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
      summary();
    end
  end

  localparam logic [31:0] B   = 32'h0010_4000;
  localparam logic [31:0] L2B = 32'h0030_0400;

  initial begin
    // table contents
    mem[{B[31:14], 12'h123, 2'b00}] = 32'hABC0_0CAA;   // section ap3 dom5 c1 b0
    mem[{B[31:14], 12'hFFF, 2'b00}] = 32'h0010_05E6;   // section ap1 dom15 c0 b1
    mem[{B[31:14], 12'h007, 2'b00}] = 32'h1234_5673;   // type 11
    mem[{B[31:14], 12'h200, 2'b00}] = 32'h0030_0521;   // table, dom 9
    for (int k = 0; k < 4; k++) begin
      put_l2(L2B, 32'h2001_0345 | (k << 14), 32'h7777_0E49);          // large, fields 3,2,1,0
      put_l2(L2B, 32'h2005_5021 + k * 32'h400, 32'h8888_81B6);        // small, fields 0,1,2,3
    end
    put_l2(L2B, 32'h2007_7000, 32'h9999_9FFF);                        // type 11

    repeat (3) @(negedge clk);
    chk(req_ready && !mem_rd && !rsp_valid, "R13 in reset",
        {29'b0, req_ready, mem_rd, rsp_valid}, 32'h4);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !mem_rd && !rsp_valid, "R13 after reset",
        {29'b0, req_ready, mem_rd, rsp_valid}, 32'h4);

    walk(32'h1234_5678, B, "R3 section");
    walk(32'hFFF0_0001, B, "R3 section top index");
    walk(32'h1234_5678, 32'h0010_7FFC, "R2 base low bits");
    walk(32'h0000_0ABC, B, "R4 type00 R10");
    walk(32'h0070_0000, B, "R4 type11 R10");
    for (int k = 0; k < 4; k++) walk(32'h2001_0345 | (k << 14), B, "R6 large");
    for (int k = 0; k < 4; k++) walk(32'h2005_5021 + k * 32'h400, B, "R7 small");
    walk(32'h2006_6000, B, "R8 invalid R10");
    walk(32'h2007_7000, B, "R8 type11 R10");
    walk(32'h2001_C345, B, "R5 R6 back to back");

    while (exp_q.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    done = 1'b1;
    summary();
  end

endmodule